// File: doc/BRIEF.md
# Dual-Limit Window Comparator

This block screens one digitized sample per watchdog instruction against two programmable thresholds. The threshold checks run back to back: the first threshold is checked in the first busy cycle, the second one in the next busy cycle. Each threshold has its own direction bit. That bit decides whether the threshold trips when the sample's magnitude lies strictly above it or strictly below it.

A sample source offers a two's-complement sample with a valid/ready handshake. The block then takes the following values from its inputs at the handshake:

- the sample itself
- both thresholds
- both direction bits
- the index of the instruction being run

If either threshold trips, the block pulses a crossing event for one cycle. This event feeds interrupt source 0 of the surrounding interrupt logic. In the same cycle the block updates a sticky status word. The status word records which thresholds tripped and which instruction tripped them. The host clears the status word by strobing a read-clear input.

Top module: `dual_limit_watch`

## Requirements
- R1: After reset, `stat_q` is zero, `cross_evt` is low, `busy` is low and `smp_ready` is high.
- R2: `smp_ready` is high only while the block is idle. A sample is accepted on a clock edge where `smp_valid` and `smp_ready` are both high. After acceptance, `busy` is high for exactly two cycles, and `smp_ready` is low for those same two cycles. An offered sample is not accepted while the block is busy.
- R3: A threshold whose direction bit is 1 trips when the sample magnitude is strictly greater than the threshold. A threshold whose direction bit is 0 trips when the magnitude is strictly less than it. A magnitude equal to the threshold never trips.
- R4: Threshold 1 is checked first and threshold 2 second. Each uses its own direction bit. A trip of threshold 1 sets `stat_q[0]`, and a trip of threshold 2 sets `stat_q[1]`.
- R5: On a trip, `stat_q[IDX_W+1:2]` takes the instruction index that was presented with the accepted sample.
- R6: If both thresholds trip in one instruction, both status bits are set and one crossing pulse is issued.
- R7: `cross_evt` is high for exactly one cycle, in the cycle in which `busy` falls, and only when at least one threshold tripped. No pulse is issued when neither threshold trips.
- R8: The status bits are sticky. They accumulate across instructions until the host reads. The index field holds the most recent tripping instruction. An instruction with no trip leaves `stat_q` unchanged.
- R9: `stat_rd` high on a clock edge clears `stat_q`. If a trip lands on the same edge, `stat_q` afterwards holds only that new trip.
- R10: The thresholds, direction bits and index are captured at acceptance. Changing them while `busy` is high has no effect on the result.
- R11: The sample is signed. The most negative code has magnitude 2^(DATA_W-1), and this magnitude compares above any threshold up to 2^(DATA_W-1)-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample offered |
| smp_ready | output | 1 | Block idle, sample can be taken |
| smp_data | input | DATA_W | Two's-complement sample |
| lim1_val | input | DATA_W | Threshold 1, unsigned |
| lim2_val | input | DATA_W | Threshold 2, unsigned |
| lim1_above | input | 1 | Threshold 1 direction (1 = trip above, 0 = trip below) |
| lim2_above | input | 1 | Threshold 2 direction (1 = trip above, 0 = trip below) |
| instr_idx | input | IDX_W | Index of the running instruction |
| stat_rd | input | 1 | Host read-clear strobe for the status word |
| stat_q | output | IDX_W+2 | Status: {index, threshold-2 bit, threshold-1 bit} |
| cross_evt | output | 1 | One-cycle crossing event (interrupt source 0) |
| busy | output | 1 | High while the threshold checks are in progress |

## Verification
Two situations are hard to reach from the ports.

The first is a host read that coincides with a new trip. To reach it, the bench counts the three register stages from acceptance to the status update and raises `stat_rd` across exactly that edge. The expected result is that only the new trip remains in `stat_q`.

The second is the retention of captured values. The bench overwrites every threshold, direction bit and index with contradicting values during both busy cycles. It then holds a second sample on the handshake while the first is still being checked, and confirms that the second sample waits for the idle cycle. The most negative code and equal-magnitude cases are driven directly to probe the edges of the magnitude comparison.

// File: rtl/dlw_pkg.sv
package dlw_pkg;

   localparam int DLW_NUM_LIM = 2;

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } dlw_state_e;

endpackage

// File: rtl/dlw_mag.sv
module dlw_mag #(
   parameter int DATA_W    = 12,
   parameter bit SIGNED_IN = 1'b1
) (
   input  logic [DATA_W-1:0] raw,
   output logic [DATA_W-1:0] mag
);

   generate
      if (SIGNED_IN) begin : g_signed
         logic [DATA_W-1:0] neg;
         assign neg = ~raw + {{(DATA_W-1){1'b0}}, 1'b1};
         assign mag = raw[DATA_W-1] ? neg : raw;
      end else begin : g_unsigned
         assign mag = raw;
      end
   endgenerate

endmodule

// File: rtl/dlw_cmp.sv
module dlw_cmp #(
   parameter int DATA_W = 12
) (
   input  logic [DATA_W-1:0] mag,
   input  logic [DATA_W-1:0] lim,
   input  logic              above,
   output logic              hit
);

   logic gt;
   logic lt;

   assign gt = mag > lim;
   assign lt = mag < lim;

   always_comb begin
      if (above) hit = gt;
      else       hit = lt;
   end

endmodule

// File: rtl/dlw_seq.sv
module dlw_seq
   import dlw_pkg::*;
#(
   parameter int DATA_W  = 12,
   parameter int IDX_W   = 3,
   parameter int NUM_LIM = DLW_NUM_LIM
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    smp_valid,
   input  logic [DATA_W-1:0]       smp_data,
   input  logic [DATA_W-1:0]       lim_in [NUM_LIM],
   input  logic [NUM_LIM-1:0]      dir_in,
   input  logic [IDX_W-1:0]        idx_in,
   input  logic                    hit_in,
   output logic                    smp_ready,
   output logic                    busy,
   output logic [DATA_W-1:0]       raw_q,
   output logic [DATA_W-1:0]       cur_lim,
   output logic                    cur_dir,
   output logic                    ev_fire,
   output logic [NUM_LIM-1:0]      ev_hits,
   output logic [IDX_W-1:0]        ev_idx
);

   localparam int PH_W = (NUM_LIM > 1) ? $clog2(NUM_LIM) : 1;
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(NUM_LIM - 1);

   dlw_state_e        state;
   logic [PH_W-1:0]   ph;
   logic [NUM_LIM-1:0] hits_acc;
   logic [DATA_W-1:0] lim_q [NUM_LIM];
   logic [NUM_LIM-1:0] dir_q;
   logic [IDX_W-1:0]  idx_q;
   logic              accept;
   logic              last;

   assign smp_ready = (state == ST_IDLE);
   assign busy      = (state == ST_RUN);
   assign accept    = smp_valid && smp_ready;
   assign last      = busy && (ph == PH_LAST);

   // capture of per-threshold settings, one register per threshold
   generate
      for (genvar g = 0; g < NUM_LIM; g++) begin : g_lim
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lim_q[g] <= '0;
               dir_q[g] <= 1'b0;
            end else if (accept) begin
               lim_q[g] <= lim_in[g];
               dir_q[g] <= dir_in[g];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         ph       <= '0;
         hits_acc <= '0;
         raw_q    <= '0;
         idx_q    <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (accept) begin
                  raw_q    <= smp_data;
                  idx_q    <= idx_in;
                  ph       <= '0;
                  hits_acc <= '0;
                  state    <= ST_RUN;
               end
            end
            ST_RUN: begin
               hits_acc[ph] <= hit_in;
               if (last) begin
                  state <= ST_IDLE;
                  ph    <= '0;
               end else begin
                  ph <= ph + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign cur_lim = lim_q[ph];
   assign cur_dir = dir_q[ph];
   assign ev_fire = last;
   assign ev_idx  = idx_q;

   always_comb begin
      for (int i = 0; i < NUM_LIM; i++) begin
         ev_hits[i] = (ph == PH_W'(i)) ? hit_in : hits_acc[i];
      end
   end

endmodule

// File: rtl/dlw_stat.sv
module dlw_stat #(
   parameter int NUM_LIM = 2,
   parameter int IDX_W   = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ev_fire,
   input  logic [NUM_LIM-1:0]       ev_hits,
   input  logic [IDX_W-1:0]         ev_idx,
   input  logic                     rd_clr,
   output logic [IDX_W+NUM_LIM-1:0] stat_q,
   output logic                     cross_q
);

   logic [NUM_LIM-1:0] hit_q;
   logic [IDX_W-1:0]   idx_q;
   logic               trip;
   logic [NUM_LIM-1:0] hit_base;

   assign trip     = ev_fire && (|ev_hits);
   assign hit_base = rd_clr ? '0 : hit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_q   <= '0;
         idx_q   <= '0;
         cross_q <= 1'b0;
      end else begin
         cross_q <= trip;
         if (trip) begin
            hit_q <= hit_base | ev_hits;
            idx_q <= ev_idx;
         end else if (rd_clr) begin
            hit_q <= '0;
            idx_q <= '0;
         end
      end
   end

   assign stat_q = {idx_q, hit_q};

endmodule

// File: rtl/dual_limit_watch.sv
module dual_limit_watch
   import dlw_pkg::*;
#(
   parameter int DATA_W    = 12,
   parameter int IDX_W     = 3,
   parameter bit SIGNED_IN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   output logic              smp_ready,
   input  logic [DATA_W-1:0] smp_data,
   input  logic [DATA_W-1:0] lim1_val,
   input  logic [DATA_W-1:0] lim2_val,
   input  logic              lim1_above,
   input  logic              lim2_above,
   input  logic [IDX_W-1:0]  instr_idx,
   input  logic              stat_rd,
   output logic [IDX_W+1:0]  stat_q,
   output logic              cross_evt,
   output logic              busy
);

   localparam int NL = DLW_NUM_LIM;

   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("dual_limit_watch: DATA_W must be at least 2");
      end
      if (IDX_W < 1) begin : g_bad_i
         $error("dual_limit_watch: IDX_W must be at least 1");
      end
      if (NL != 2) begin : g_bad_n
         $error("dual_limit_watch: port list is built for two thresholds");
      end
   endgenerate

   logic [DATA_W-1:0] lim_bus [NL];
   logic [NL-1:0]     dir_bus;
   logic [DATA_W-1:0] raw_q;
   logic [DATA_W-1:0] mag;
   logic [DATA_W-1:0] cur_lim;
   logic              cur_dir;
   logic              hit;
   logic              ev_fire;
   logic [NL-1:0]     ev_hits;
   logic [IDX_W-1:0]  ev_idx;

   assign lim_bus[0] = lim1_val;
   assign lim_bus[1] = lim2_val;
   assign dir_bus    = {lim2_above, lim1_above};

   dlw_seq #(
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W),
      .NUM_LIM(NL)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp_valid(smp_valid),
      .smp_data (smp_data),
      .lim_in   (lim_bus),
      .dir_in   (dir_bus),
      .idx_in   (instr_idx),
      .hit_in   (hit),
      .smp_ready(smp_ready),
      .busy     (busy),
      .raw_q    (raw_q),
      .cur_lim  (cur_lim),
      .cur_dir  (cur_dir),
      .ev_fire  (ev_fire),
      .ev_hits  (ev_hits),
      .ev_idx   (ev_idx)
   );

   dlw_mag #(
      .DATA_W   (DATA_W),
      .SIGNED_IN(SIGNED_IN)
   ) u_mag (
      .raw(raw_q),
      .mag(mag)
   );

   dlw_cmp #(
      .DATA_W(DATA_W)
   ) u_cmp (
      .mag  (mag),
      .lim  (cur_lim),
      .above(cur_dir),
      .hit  (hit)
   );

   dlw_stat #(
      .NUM_LIM(NL),
      .IDX_W  (IDX_W)
   ) u_stat (
      .clk    (clk),
      .rst_n  (rst_n),
      .ev_fire(ev_fire),
      .ev_hits(ev_hits),
      .ev_idx (ev_idx),
      .rd_clr (stat_rd),
      .stat_q (stat_q),
      .cross_q(cross_evt)
   );

endmodule

// File: rtl/dlw_chk.sv
module dlw_chk #(
   parameter int IDX_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             smp_valid,
   input logic             smp_ready,
   input logic             stat_rd,
   input logic [IDX_W+1:0] stat_q,
   input logic             cross_evt,
   input logic             busy
);

   AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && smp_ready) |=> (busy && !smp_ready)); // R2

   AST_BUSY_TWO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |=> busy); // R2

   AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |=> !busy); // R2

   AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      cross_evt |=> !cross_evt); // R7

   AST_PULSE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      cross_evt |-> $fell(busy)); // R7

   AST_PULSE_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
      cross_evt |-> (stat_q[1:0] != 2'b00)); // R4

   AST_STICKY_L1: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[0] && !stat_rd) |=> stat_q[0]); // R8

   AST_STICKY_L2: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[1] && !stat_rd) |=> stat_q[1]); // R8

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_rd && !busy) |=> $stable(stat_q)); // R8

   AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !busy) |=> (stat_q == '0)); // R9

endmodule

bind dual_limit_watch dlw_chk #(
   .IDX_W(IDX_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .smp_valid(smp_valid),
   .smp_ready(smp_ready),
   .stat_rd  (stat_rd),
   .stat_q   (stat_q),
   .cross_evt(cross_evt),
   .busy     (busy)
);

// File: tb/dual_limit_watch_test.sv
module dual_limit_watch_test;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 12;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          smp_valid = 1'b0;
   logic          smp_ready;
   logic [DW-1:0] smp_data = '0;
   logic [DW-1:0] lim1_val = '0;
   logic [DW-1:0] lim2_val = '0;
   logic          lim1_above = 1'b0;
   logic          lim2_above = 1'b0;
   logic [IW-1:0] instr_idx = '0;
   logic          stat_rd = 1'b0;
   logic [IW+1:0] stat_q;
   logic          cross_evt;
   logic          busy;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   dual_limit_watch #(.DATA_W(DW), .IDX_W(IW)) uut (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
      .smp_data(smp_data), .lim1_val(lim1_val), .lim2_val(lim2_val),
      .lim1_above(lim1_above), .lim2_above(lim2_above), .instr_idx(instr_idx),
      .stat_rd(stat_rd), .stat_q(stat_q), .cross_evt(cross_evt), .busy(busy)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int stat_word(input int idx, input int h2, input int h1);
      return (idx << 2) | (h2 << 1) | h1;
   endfunction

   // one instruction; inputs are scrambled during busy (R10)
   task automatic run_instr(input logic [DW-1:0] s, input logic [DW-1:0] l1,
                            input logic [DW-1:0] l2, input logic d1, input logic d2,
                            input logic [IW-1:0] idx, input bit rd_end,
                            input int exp_pulse);
      @(negedge clk);
      smp_valid = 1'b1; smp_data = s; lim1_val = l1; lim2_val = l2;
      lim1_above = d1; lim2_above = d2; instr_idx = idx;
      @(negedge clk);
      smp_valid = 1'b0;
      check("R2 busy after accept", int'(busy), 1);
      check("R2 ready low while busy", int'(smp_ready), 0);
      smp_data = ~s; lim1_val = ~l1; lim2_val = ~l2;
      lim1_above = ~d1; lim2_above = ~d2; instr_idx = ~idx;
      @(negedge clk);
      check("R2 busy second cycle", int'(busy), 1);
      check("R7 no early pulse", int'(cross_evt), 0);
      stat_rd = rd_end;
      @(negedge clk);
      stat_rd = 1'b0;
      check("R2 busy dropped", int'(busy), 0);
      check("R7 pulse at end", int'(cross_evt), exp_pulse);
      @(negedge clk);
      check("R7 pulse one cycle", int'(cross_evt), 0);
   endtask

   task automatic host_read();
      @(negedge clk);
      stat_rd = 1'b1;
      @(negedge clk);
      stat_rd = 1'b0;
      check("R9 read clears", int'(stat_q), 0);
   endtask

   task automatic t_reset();
      check("R1 stat", int'(stat_q), 0);
      check("R1 cross", int'(cross_evt), 0);
      check("R1 busy", int'(busy), 0);
      check("R1 ready", int'(smp_ready), 1);
   endtask

   task automatic t_above();
      run_instr(12'd300, 12'd200, 12'd1000, 1'b1, 1'b1, 3'd5, 1'b0, 1);
      check("R3 R4 R5 above trip", int'(stat_q), stat_word(5, 0, 1));
      host_read();
   endtask

   task automatic t_below();
      run_instr(12'hFCE, 12'd20, 12'd60, 1'b0, 1'b0, 3'd2, 1'b0, 1);
      check("R3 R4 R10 below trip", int'(stat_q), stat_word(2, 1, 0));
      host_read();
   endtask

   task automatic t_equal();
      run_instr(12'hFB3, 12'd77, 12'd77, 1'b1, 1'b0, 3'd4, 1'b0, 0);
      check("R3 equal no trip", int'(stat_q), 0);
   endtask

   task automatic t_both();
      run_instr(12'd1000, 12'd500, 12'd1500, 1'b1, 1'b0, 3'd7, 1'b0, 1);
      check("R6 both thresholds", int'(stat_q), stat_word(7, 1, 1));
      host_read();
   endtask

   task automatic t_sticky();
      run_instr(12'd900, 12'd800, 12'd2000, 1'b1, 1'b1, 3'd1, 1'b0, 1);
      check("R8 first trip", int'(stat_q), stat_word(1, 0, 1));
      run_instr(12'd3196, 12'd950, 12'd950, 1'b1, 1'b0, 3'd4, 1'b0, 1);
      check("R8 accumulate", int'(stat_q), stat_word(4, 1, 1));
      run_instr(12'd10, 12'd5, 12'd20, 1'b0, 1'b1, 3'd6, 1'b0, 0);
      check("R8 quiet keeps status", int'(stat_q), stat_word(4, 1, 1));
   endtask

   task automatic t_collide();
      run_instr(12'd100, 12'd50, 12'd200, 1'b1, 1'b1, 3'd3, 1'b1, 1);
      check("R9 read with new trip", int'(stat_q), stat_word(3, 0, 1));
      host_read();
   endtask

   task automatic t_min_neg();
      run_instr(12'h800, 12'd2047, 12'd4095, 1'b1, 1'b0, 3'd0, 1'b0, 1);
      check("R11 most negative code", int'(stat_q), stat_word(0, 1, 1));
      host_read();
   endtask

   task automatic t_backpressure();
      int pulses = 0;
      @(negedge clk);
      smp_valid = 1'b1; smp_data = 12'd400; lim1_val = 12'd100; lim2_val = 12'd0;
      lim1_above = 1'b1; lim2_above = 1'b0; instr_idx = 3'd2;
      @(negedge clk);
      smp_data = 12'd5; lim1_val = 12'd10; lim2_val = 12'd3;
      lim1_above = 1'b0; lim2_above = 1'b1; instr_idx = 3'd6;
      check("R2 held sample waits", int'(smp_ready), 0);
      @(negedge clk);
      check("R2 held sample waits 2", int'(smp_ready), 0);
      @(negedge clk);
      if (cross_evt) pulses++;
      check("R2 idle returns", int'(smp_ready), 1);
      @(negedge clk);
      smp_valid = 1'b0;
      check("R2 second accepted", int'(busy), 1);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         if (cross_evt) pulses++;
      end
      check("R7 two pulses", pulses, 2);
      check("R5 R8 second index", int'(stat_q), stat_word(6, 1, 1));
      host_read();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_above();
      t_below();
      t_equal();
      t_both();
      t_sticky();
      host_read();
      t_sticky();
      t_collide();
      t_min_neg();
      t_backpressure();
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule